// File: doc/BRIEF.md
# SCSI Initiator Phase Sequencer

This block is a hardware bus master for a SCSI bus with a single initiator. The host pulses a start strobe together with a target number and a data length. The sequencer then waits until the bus is free and selects the target without arbitration. After that it follows whichever information phase the target signals: command, data out, data in, status or message in. Each byte moves with the REQ/ACK handshake. When the target releases BSY, the block posts a one-byte result code and the captured status byte.

The host side has three byte streams. Command bytes and write bytes are consumed through pop strobes, and read bytes come out with a one-cycle valid pulse. On the bus side, every open-collector line the initiator can pull is modelled as a separate active-high drive enable. The target-driven lines are active-high inputs meaning "asserted", and they are taken as already synchronous to `clk`. Result codes are 0x00 for success, 0xE0 for selection timeout and 0xE1 for bad status.

Top module: `scsi_init_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_sel_oe`, `bus_ack_oe` and `bus_db_oe` are low. A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` pulses, and `done` is only seen with `busy` low. A `start` pulse while `busy` is high has no effect.
- R2: Selection does not begin while `bus_bsy` is asserted. `bus_sel_oe` stays low until `bus_bsy` has been seen low.
- R3: During selection, `bus_sel_oe` and `bus_db_oe` are high and `bus_db_out` carries bit 7 (the initiator's own ID) ORed with bit N, where N is `target_id`. `bus_sel_oe` drops on the cycle after `bus_bsy` is first seen high.
- R4: If `bus_bsy` never appears, `bus_sel_oe` is held for SEL_TICKS+1 cycles. The block then ends with result 0xE0 and a status byte of 0x00.
- R5: When `bus_req` is high, the phase is decoded from {C/D, MSG, I/O}: 000 is data out, 001 is data in, 100 is command, 101 is status, 110 is message out and 111 is message in.
- R6: ACK is raised only after REQ has been seen and is held until REQ drops or BSY is lost. Outgoing bytes are driven on `bus_db_out` with `bus_db_oe` while ACK is high. An incoming byte appears on `rd_byte` with `rd_valid` high in the first ACK cycle. The status byte is latched from `bus_db_in`.
- R7: If BSY is lost during any wait after selection, the block goes straight to completion, and the result is graded from the status captured so far.
- R8: In command and data phases, the current phase is checked against the entered phase before each byte. On a mismatch, no byte is moved and phase decoding resumes. Command bytes are popped until the target leaves the command phase.
- R9: Data phases move exactly `xfer_len` bytes in total per transaction. Further data-phase requests are never acknowledged.
- R10: A message-in byte is acknowledged and not interpreted. The block then waits, still busy, until BSY drops. A message-out request is never acknowledged.
- R11: On completion (other than timeout), the result is 0x00 if (status AND 0x0E) is 0x00 or 0x04, and 0xE1 otherwise. `status_byte` shows the captured status, or 0x00 if no status phase took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (taken only while idle) |
| target_id | input | ID_W | Target number to select |
| xfer_len | input | LEN_W | Total data-phase byte count |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when result is posted |
| result | output | 8 | Result code |
| status_byte | output | 8 | Captured status byte |
| cmd_byte | input | 8 | Head of command stream |
| cmd_pop | output | 1 | Consume command head |
| wr_byte | input | 8 | Head of write-data stream |
| wr_pop | output | 1 | Consume write-data head |
| rd_byte | output | 8 | Received data byte |
| rd_valid | output | 1 | `rd_byte` valid pulse |
| bus_db_in | input | 8 | Data bus as seen on the wire |
| bus_db_out | output | 8 | Data bus value to drive |
| bus_db_oe | output | 1 | Data bus drive enable |
| bus_bsy | input | 1 | BSY asserted |
| bus_sel_oe | output | 1 | Pull SEL |
| bus_req | input | 1 | REQ asserted |
| bus_ack_oe | output | 1 | Pull ACK |
| bus_cd | input | 1 | C/D line |
| bus_msg | input | 1 | MSG line |
| bus_io | input | 1 | I/O line |

## Verification
The sharpest case is a loss of BSY arriving while REQ is still asserted and ACK is up. At that edge the handshake release and the completion path compete for the next state. The bench raises REQ for a data-out byte, waits for ACK, and then drops BSY with REQ still high. Completion must win: `done` must follow with a success result, and exactly one write byte must have been popped. A second overlap is a data-phase request arriving just as the byte count reaches zero. The bench checks that this request is left unacknowledged while later phases still run.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

  localparam int DB_W = 8;

  localparam logic [DB_W-1:0] RES_OK          = 8'h00;
  localparam logic [DB_W-1:0] RES_SEL_TIMEOUT = 8'hE0;
  localparam logic [DB_W-1:0] RES_BAD_STATUS  = 8'hE1;
  localparam logic [DB_W-1:0] STAT_MASK       = 8'h0E;

  typedef enum logic [2:0] {
    PH_DOUT, PH_DIN, PH_CMD, PH_STAT, PH_MOUT, PH_MIN
  } bus_phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_FREE, S_SELECT, S_EVAL, S_XFER, S_ACK, S_DRAIN, S_FINISH
  } seq_state_e;

  function automatic logic is_data(input bus_phase_e p);
    return (p == PH_DOUT) || (p == PH_DIN);
  endfunction

  function automatic logic [DB_W-1:0] grade_status(input logic [DB_W-1:0] s);
    logic [DB_W-1:0] m;
    m = s & STAT_MASK;
    return ((m == 8'h00) || (m == 8'h04)) ? RES_OK : RES_BAD_STATUS;
  endfunction

endpackage

// File: rtl/scsi_phase_decode.sv
module scsi_phase_decode
  import scsi_seq_pkg::*;
(
  input  logic       cd,
  input  logic       msg,
  input  logic       io,
  output bus_phase_e phase
);

  always_comb begin
    if (!cd) begin
      phase = io ? PH_DIN : PH_DOUT;
    end else if (msg) begin
      phase = io ? PH_MIN : PH_MOUT;
    end else begin
      phase = io ? PH_STAT : PH_CMD;
    end
  end

endmodule

// File: rtl/scsi_sel_timer.sv
module scsi_sel_timer #(
  parameter int TICKS = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int W = $clog2(TICKS + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = W'(TICKS);
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/scsi_len_count.sv
module scsi_len_count #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             empty
);

  logic [LEN_W-1:0] left_q, left_d;
  logic             left_en;

  always_comb begin
    left_d  = left_q;
    left_en = 1'b0;
    if (load) begin
      left_d  = load_val;
      left_en = 1'b1;
    end else if (dec && (left_q != '0)) begin
      left_d  = left_q - LEN_W'(1);
      left_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= left_d;
    end
  end

  assign empty = (left_q == '0);

endmodule

// File: rtl/scsi_init_seq.sv
module scsi_init_seq
  import scsi_seq_pkg::*;
#(
  parameter int ID_W      = 3,
  parameter int LEN_W     = 16,
  parameter int SEL_TICKS = 2000,
  parameter int INIT_ID   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ID_W-1:0]  target_id,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             busy,
  output logic             done,
  output logic [DB_W-1:0]  result,
  output logic [DB_W-1:0]  status_byte,
  input  logic [DB_W-1:0]  cmd_byte,
  output logic             cmd_pop,
  input  logic [DB_W-1:0]  wr_byte,
  output logic             wr_pop,
  output logic [DB_W-1:0]  rd_byte,
  output logic             rd_valid,
  input  logic [DB_W-1:0]  bus_db_in,
  output logic [DB_W-1:0]  bus_db_out,
  output logic             bus_db_oe,
  input  logic             bus_bsy,
  output logic             bus_sel_oe,
  input  logic             bus_req,
  output logic             bus_ack_oe,
  input  logic             bus_cd,
  input  logic             bus_msg,
  input  logic             bus_io
);

  seq_state_e       state_q, state_d;
  bus_phase_e       phase_q, cur_ph;
  logic [ID_W-1:0]  tgt_q;
  logic [DB_W-1:0]  db_q, rd_q, stat_q, result_q, sel_byte;
  logic             done_q, rd_valid_q, timeout_q;

  logic accept, tim_load, tim_run, tim_exp;
  logic cnt_dec, cnt_empty;
  logic phase_en, take_out, take_in, cap_stat, set_to, post;

  scsi_phase_decode u_dec (
    .cd    (bus_cd),
    .msg   (bus_msg),
    .io    (bus_io),
    .phase (cur_ph)
  );

  scsi_sel_timer #(.TICKS(SEL_TICKS)) u_tim (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tim_load),
    .run     (tim_run),
    .expired (tim_exp)
  );

  scsi_len_count #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (xfer_len),
    .dec      (cnt_dec),
    .empty    (cnt_empty)
  );

  always_comb begin
    sel_byte          = '0;
    sel_byte[INIT_ID] = 1'b1;
    sel_byte[tgt_q]   = 1'b1;
  end

  // next-state and control strobes
  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    tim_load = 1'b0;
    tim_run  = 1'b0;
    cnt_dec  = 1'b0;
    phase_en = 1'b0;
    take_out = 1'b0;
    take_in  = 1'b0;
    cap_stat = 1'b0;
    set_to   = 1'b0;
    post     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_d = S_WAIT_FREE;
        end
      end
      S_WAIT_FREE: begin
        if (!bus_bsy) begin
          tim_load = 1'b1;
          state_d  = S_SELECT;
        end
      end
      S_SELECT: begin
        if (bus_bsy) begin
          state_d = S_EVAL;
        end else if (tim_exp) begin
          set_to  = 1'b1;
          state_d = S_FINISH;
        end else begin
          tim_run = 1'b1;
        end
      end
      S_EVAL: begin
        if (!bus_bsy) begin
          state_d = S_FINISH;
        end else if (bus_req) begin
          phase_en = 1'b1;
          case (cur_ph)
            PH_DOUT, PH_DIN: if (!cnt_empty) state_d = S_XFER;
            PH_CMD:          state_d = S_XFER;
            PH_STAT: begin
              cap_stat = 1'b1;
              state_d  = S_ACK;
            end
            PH_MIN:          state_d = S_ACK;
            default:         state_d = S_EVAL;
          endcase
        end
      end
      S_XFER: begin
        if (!bus_bsy) begin
          state_d = S_FINISH;
        end else if (bus_req) begin
          if ((cur_ph != phase_q) || (is_data(phase_q) && cnt_empty)) begin
            state_d = S_EVAL;
          end else begin
            state_d  = S_ACK;
            take_in  = (phase_q == PH_DIN);
            take_out = (phase_q != PH_DIN);
            cnt_dec  = is_data(phase_q);
          end
        end
      end
      S_ACK: begin
        if (!bus_bsy) begin
          state_d = S_FINISH;
        end else if (!bus_req) begin
          if (phase_q == PH_MIN)       state_d = S_DRAIN;
          else if (phase_q == PH_STAT) state_d = S_EVAL;
          else                         state_d = S_XFER;
        end
      end
      S_DRAIN: begin
        if (!bus_bsy) state_d = S_FINISH;
      end
      S_FINISH: begin
        post    = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      phase_q    <= PH_DOUT;
      tgt_q      <= '0;
      db_q       <= '0;
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
      stat_q     <= '0;
      timeout_q  <= 1'b0;
      result_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= take_in;
      done_q     <= post;
      if (accept) tgt_q <= target_id;
      if (phase_en) phase_q <= cur_ph;
      if (take_out) db_q <= (phase_q == PH_CMD) ? cmd_byte : wr_byte;
      if (take_in) rd_q <= bus_db_in;
      if (accept) begin
        stat_q <= '0;
      end else if (cap_stat) begin
        stat_q <= bus_db_in;
      end
      if (accept) begin
        timeout_q <= 1'b0;
      end else if (set_to) begin
        timeout_q <= 1'b1;
      end
      if (post) result_q <= timeout_q ? RES_SEL_TIMEOUT : grade_status(stat_q);
    end
  end

  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign result      = result_q;
  assign status_byte = stat_q;
  assign rd_byte     = rd_q;
  assign rd_valid    = rd_valid_q;
  assign cmd_pop     = take_out && (phase_q == PH_CMD);
  assign wr_pop      = take_out && (phase_q == PH_DOUT);
  assign bus_sel_oe  = (state_q == S_SELECT);
  assign bus_ack_oe  = (state_q == S_ACK);
  assign bus_db_oe   = (state_q == S_SELECT) ||
                       ((state_q == S_ACK) && ((phase_q == PH_CMD) || (phase_q == PH_DOUT)));
  assign bus_db_out  = (state_q == S_SELECT) ? sel_byte : db_q;

endmodule

// File: rtl/scsi_seq_checker.sv
module scsi_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic bus_sel_oe,
  input logic bus_bsy,
  input logic bus_req,
  input logic bus_ack_oe,
  input logic bus_db_oe,
  input logic rd_valid
);

  a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r1_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_bus_free_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_sel_oe) |-> !$past(bus_bsy));

  a_r3_sel_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_oe && bus_bsy) |=> !bus_sel_oe);

  a_r3_no_ack_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack_oe && bus_sel_oe));

  a_r6_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_oe) |-> $past(bus_req));

  a_r6_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_oe) |-> (!$past(bus_req) || !$past(bus_bsy)));

  a_r6_read_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (bus_ack_oe && !bus_db_oe));

endmodule

bind scsi_init_seq scsi_seq_checker u_chk (.*);

// File: tb/sim_scsi_init_seq.sv
module sim_scsi_init_seq;
  import scsi_seq_pkg::*;

  localparam int ID_W  = 3;
  localparam int LEN_W = 16;
  localparam int SEL_T = 40;

  localparam logic [2:0] P_DOUT = 3'b000, P_DIN = 3'b001, P_CMD = 3'b100,
                         P_STAT = 3'b101, P_MOUT = 3'b110, P_MIN = 3'b111;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic             start;
  logic [ID_W-1:0]  target_id;
  logic [LEN_W-1:0] xfer_len;
  logic             busy, done;
  logic [7:0]       result, status_byte;
  logic [7:0]       cmd_byte, wr_byte, rd_byte;
  logic             cmd_pop, wr_pop, rd_valid;
  logic [7:0]       bus_db_in, bus_db_out;
  logic             bus_db_oe, bus_bsy, bus_sel_oe, bus_req, bus_ack_oe;
  logic             bus_cd, bus_msg, bus_io;

  scsi_init_seq #(.ID_W(ID_W), .LEN_W(LEN_W), .SEL_TICKS(SEL_T), .INIT_ID(7)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_id(target_id), .xfer_len(xfer_len),
    .busy(busy), .done(done), .result(result), .status_byte(status_byte),
    .cmd_byte(cmd_byte), .cmd_pop(cmd_pop), .wr_byte(wr_byte), .wr_pop(wr_pop),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .bus_db_in(bus_db_in), .bus_db_out(bus_db_out),
    .bus_db_oe(bus_db_oe), .bus_bsy(bus_bsy), .bus_sel_oe(bus_sel_oe), .bus_req(bus_req),
    .bus_ack_oe(bus_ack_oe), .bus_cd(bus_cd), .bus_msg(bus_msg), .bus_io(bus_io)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] cmd_mem [16];
  logic [7:0] wr_mem  [16];
  int         cmd_idx, wr_idx;
  logic       idx_clr;

  always @(posedge clk) begin
    if (idx_clr) begin
      cmd_idx <= 0;
      wr_idx  <= 0;
    end else begin
      if (cmd_pop) cmd_idx <= cmd_idx + 1;
      if (wr_pop)  wr_idx  <= wr_idx + 1;
    end
  end
  assign cmd_byte = cmd_mem[cmd_idx[3:0]];
  assign wr_byte  = wr_mem[wr_idx[3:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] exp_sel(input int t);
    logic [7:0] v;
    v = 8'h80;
    v[t[2:0]] = 1'b1;
    return v;
  endfunction

  function automatic logic [7:0] exp_res(input logic [7:0] st);
    logic [7:0] m;
    m = st & 8'h0E;
    return ((m == 8'h00) || (m == 8'h04)) ? 8'h00 : 8'hE1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(input logic lvl, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bus_ack_oe === lvl) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done === 1'b1) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic tgt_cycle(input logic [2:0] ph, input logic [7:0] din,
                           output logic [7:0] dout, output bit acked, output bit rdv);
    bit ok2;
    {bus_cd, bus_msg, bus_io} = ph;
    bus_db_in = din;
    bus_req   = 1'b1;
    wait_ack(1'b1, acked);
    dout = bus_db_out;
    rdv  = rd_valid && (rd_byte == din);
    bus_req = 1'b0;
    if (acked) wait_ack(1'b0, ok2);
  endtask

  task automatic probe_no_ack(input logic [2:0] ph, input string tag);
    bit seen;
    seen = 1'b0;
    {bus_cd, bus_msg, bus_io} = ph;
    bus_req = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (bus_ack_oe) seen = 1'b1;
    end
    chk(tag, seen, 0);
    bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic begin_txn(input int tgt, input int nd, input bit prebusy);
    bit seen;
    for (int i = 0; i < 16; i++) begin
      cmd_mem[i] = 8'($urandom);
      wr_mem[i]  = 8'($urandom);
    end
    idx_clr = 1'b1;
    @(negedge clk);
    idx_clr = 1'b0;
    if (prebusy) bus_bsy = 1'b1;
    start = 1'b1;
    target_id = ID_W'(tgt);
    xfer_len = LEN_W'(nd);
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", busy, 1);
    if (prebusy) begin
      seen = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (bus_sel_oe) seen = 1'b1;
      end
      chk("R2 no SEL while BSY held", seen, 0);
      bus_bsy = 1'b0;
    end
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (bus_sel_oe) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    chk("R3 SEL asserted", seen, 1);
    chk("R3 select byte", bus_db_out, exp_sel(tgt));
    chk("R3 data bus driven", bus_db_oe, 1);
    bus_bsy = 1'b1;
    @(negedge clk);
    chk("R3 SEL released after BSY", bus_sel_oe, 0);
  endtask

  task automatic run_txn(input int tgt, input int ncmd, input int dir, input int nd,
                         input logic [7:0] st, input bit prebusy, input bit extra,
                         input bit mout, input bit midstart);
    logic [7:0] d;
    logic [7:0] rnd;
    bit a, r, ok;
    begin_txn(tgt, nd, prebusy);
    if (midstart) begin
      start = 1'b1;
      target_id = ID_W'(tgt + 1);
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < ncmd; i++) begin
      tgt_cycle(P_CMD, 8'h00, d, a, r);
      chk("R6 command byte on bus", d, cmd_mem[i]);
    end
    for (int i = 0; i < nd; i++) begin
      if (dir == 1) begin
        tgt_cycle(P_DOUT, 8'h00, d, a, r);
        chk("R6 write byte on bus", d, wr_mem[i]);
      end else begin
        rnd = 8'($urandom);
        tgt_cycle(P_DIN, rnd, d, a, r);
        chk("R6 read byte delivered", r, 1);
      end
    end
    if (extra) probe_no_ack((dir == 2) ? P_DIN : P_DOUT, "R9 excess data not acked");
    if (mout)  probe_no_ack(P_MOUT, "R10 message-out not acked");
    tgt_cycle(P_STAT, st, d, a, r);
    chk("R5 status phase acked", a, 1);
    tgt_cycle(P_MIN, 8'h00, d, a, r);
    chk("R10 message-in acked", a, 1);
    repeat (3) @(negedge clk);
    chk("R10 waits for BSY drop", busy, 1);
    bus_bsy = 1'b0;
    wait_done(ok);
    chk("R1 done pulse", ok, 1);
    chk("R1 idle at done", busy, 0);
    chk("R11 result code", result, exp_res(st));
    chk("R11 status byte", status_byte, st);
    chk("R8 command bytes popped", cmd_idx, ncmd);
    chk("R9 write bytes popped", wr_idx, (dir == 1) ? nd : 0);
    if (midstart) begin
      ok = 1'b0;
      repeat (6) begin
        @(negedge clk);
        if (bus_sel_oe || busy) ok = 1'b1;
      end
      chk("R1 start while busy ignored", ok, 0);
    end
  endtask

  initial begin
    logic [7:0] d;
    bit a, r, ok;
    int n;
    void'($urandom(32'h5C51));
    rst_n = 1'b0;
    start = 1'b0; target_id = '0; xfer_len = '0;
    bus_db_in = '0; bus_bsy = 1'b0; bus_req = 1'b0;
    bus_cd = 1'b0; bus_msg = 1'b0; bus_io = 1'b0;
    idx_clr = 1'b1;
    for (int i = 0; i < 16; i++) begin
      cmd_mem[i] = 8'h00;
      wr_mem[i]  = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset SEL", bus_sel_oe, 0);
    chk("R1 reset ACK", bus_ack_oe, 0);
    chk("R1 reset data drive", bus_db_oe, 0);

    // directed corner cases
    run_txn(3, 6, 1, 4, 8'h00, 0, 0, 0, 0);
    run_txn(0, 10, 2, 5, 8'h02, 0, 0, 0, 0);
    run_txn(6, 6, 0, 0, 8'h04, 1, 0, 0, 0);
    run_txn(1, 12, 1, 2, 8'h08, 0, 1, 0, 0);
    run_txn(2, 6, 2, 3, 8'h11, 0, 1, 1, 0);
    run_txn(4, 1, 0, 0, 8'hF5, 0, 1, 1, 1);
    run_txn(5, 3, 1, 1, 8'h0C, 0, 0, 0, 0);

    // R4 selection timeout
    begin
      start = 1'b1; target_id = 3'd5; xfer_len = '0;
      @(negedge clk);
      start = 1'b0;
      n = 0; ok = 1'b0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (bus_sel_oe) n++;
        if (done) begin
          ok = 1'b1;
          break;
        end
      end
      chk("R4 timeout completes", ok, 1);
      chk("R4 SEL held cycles", n, SEL_T + 1);
      chk("R4 timeout result", result, 8'hE0);
      chk("R4 timeout status", status_byte, 0);
    end

    // R7 BSY lost while REQ still high during ACK
    begin
      begin_txn(2, 3, 0);
      tgt_cycle(P_CMD, 8'h00, d, a, r);
      chk("R7 cmd byte", d, cmd_mem[0]);
      {bus_cd, bus_msg, bus_io} = P_DOUT;
      bus_req = 1'b1;
      wait_ack(1'b1, a);
      chk("R7 data ack", a, 1);
      bus_bsy = 1'b0;
      wait_done(ok);
      bus_req = 1'b0;
      chk("R7 done on BSY loss", ok, 1);
      chk("R7 result on BSY loss", result, 8'h00);
      chk("R7 one write byte", wr_idx, 1);
    end

    // constrained random transactions
    for (int k = 0; k < 10; k++) begin
      int t, nc, dr, ndd;
      t   = int'($urandom % 7);
      nc  = 1 + int'($urandom % 10);
      dr  = int'($urandom % 3);
      ndd = (dr != 0) ? 1 + int'($urandom % 12) : 0;
      run_txn(t, nc, dr, ndd, 8'($urandom), ($urandom % 4) == 0,
              ($urandom % 3) == 0, ($urandom % 3) == 0, 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule